// File: doc/BRIEF.md
# Mixed-Rate Tester Lane Expander

This block sits between a small group of tester pins and the scan-in and scan-out lines of the cores on the chip. The tester drives some of its pins much faster than the cores can shift. Each fast input pin is spread over several slow lines toward the cores. In the return direction, each matching group of slow response lines is packed back onto one fast output pin. The remaining tester pins carry one slow line each and pass straight through. The cores therefore see a test access width larger than the number of tester pins.

Everything runs on the single fast clock. A phase counter splits time into slow periods of `RATIO` fast cycles. A one-cycle strobe marks the first fast cycle of each slow period, and the cores advance their scan chains on that strobe. All slow lines, whether they are expanded or passed through, change on the same edge, so the cores always see one consistent slow word. The count of fast pins (`FAST_PINS`), the rate factor (`RATIO`) and the upper bound on the virtual width (`WMAX`) are parameters.

Top module: `vtam_rate_bridge`

## Requirements
- R1: The core-side width is (ATE_PINS − FAST_PINS) + FAST_PINS·RATIO. This is 10 lines with the defaults ATE_PINS=4, FAST_PINS=2, RATIO=4. Elaboration fails if the width exceeds WMAX.
- R2: `slow_en` is low during reset. It is first high RATIO fast cycles after reset is released, and from then on it is high for exactly one cycle in every RATIO.
- R3: Phase 0 is the first fast cycle after reset is released, and phases count 0 to RATIO−1 in each slow period. The bit on fast pin `ate_in[g]` (g < FAST_PINS) in phase p appears on `tam_out[g*RATIO+p]`.
- R4: `tam_out` changes only at the edge that raises `slow_en`, and it holds for the whole slow period. A partly collected word is never visible.
- R5: The slow input pin `ate_in[FAST_PINS+s]` is sampled only in phase RATIO−1. It appears on `tam_out[FAST_PINS*RATIO+s]` together with the expanded word. Its value in the other phases has no effect.
- R6: `tam_in` is sampled only in phase RATIO−1. During phase p of the next slow period, fast output pin `ate_out[g]` carries `tam_in[g*RATIO+p]`, so line 0 goes out first. The value of `tam_in` in the other phases has no effect.
- R7: The slow output pin `ate_out[FAST_PINS+s]` takes `tam_in[FAST_PINS*RATIO+s]` at the same sampling point as R6 and holds it for the whole next slow period.
- R8: A synchronous reset, applied in any phase, clears `tam_out`, `ate_out` and `slow_en` and restarts the phase count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tester-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| ate_in | input | ATE_PINS | Tester stimulus pins; bits below FAST_PINS are fast |
| ate_out | output | ATE_PINS | Tester response pins; bits below FAST_PINS are fast |
| tam_out | output | VWIDTH | Slow stimulus lines toward the cores |
| tam_in | input | VWIDTH | Slow response lines from the cores |
| slow_en | output | 1 | One-cycle strobe at the start of each slow period |

## Verification
A phase counter that drifts or restarts at the wrong time shows at the ports within one slow period. `slow_en` moves, and the stimulus words come out rotated: a bit lands on the wrong line of its group. A fault in a collecting register shows on `tam_out` at the next strobe. A fault in a packing register shows on the fast `ate_out` pins during the slow period that follows, so at most two slow periods after the bad sample. The bench drives the complement of the real data in every phase that must be ignored, and it checks `tam_out` in every fast cycle. This exposes sampling at the wrong phase and any change to the slow word in the middle of a period.

// File: rtl/vtam_pkg.sv
package vtam_pkg;
    function automatic int unsigned virt_width(int unsigned ate_pins,
                                               int unsigned fast_pins,
                                               int unsigned ratio);
        return (ate_pins - fast_pins) + fast_pins * ratio;
    endfunction
endpackage

// File: rtl/vtam_phase.sv
module vtam_phase #(
    parameter int unsigned RATIO = 4
) (
    input  logic clk,
    input  logic rst,
    output logic last_phase,
    output logic strobe
);
    localparam int unsigned PW = (RATIO > 1) ? $clog2(RATIO) : 1;

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          strobe;
    } phase_st_t;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        last_phase = (st_q.phase == PW'(RATIO - 1));
        st_d.strobe = last_phase;
        st_d.phase  = last_phase ? '0 : st_q.phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign strobe = st_q.strobe;
endmodule

// File: rtl/vtam_sipo.sv
module vtam_sipo #(
    parameter int unsigned RATIO = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             last_phase,
    input  logic             bit_in,
    output logic [RATIO-1:0] word
);
    typedef struct packed {
        logic [RATIO-1:0] col;
        logic [RATIO-1:0] word;
    } sipo_st_t;

    sipo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.col = {bit_in, st_q.col[RATIO-1:1]};
        if (last_phase) st_d.word = {bit_in, st_q.col[RATIO-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word = st_q.word;
endmodule

// File: rtl/vtam_piso.sv
module vtam_piso #(
    parameter int unsigned RATIO = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             last_phase,
    input  logic [RATIO-1:0] par_in,
    output logic             bit_out
);
    typedef struct packed {
        logic [RATIO-1:0] sh;
    } piso_st_t;

    piso_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (last_phase) st_d.sh = par_in;
        else            st_d.sh = {1'b0, st_q.sh[RATIO-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bit_out = st_q.sh[0];
endmodule

// File: rtl/vtam_rate_bridge.sv
module vtam_rate_bridge
    import vtam_pkg::*;
#(
    parameter int unsigned ATE_PINS  = 4,
    parameter int unsigned FAST_PINS = 2,
    parameter int unsigned RATIO     = 4,
    parameter int unsigned WMAX      = 16,
    localparam int unsigned SLOW_PINS = ATE_PINS - FAST_PINS,
    localparam int unsigned FAST_LINES = FAST_PINS * RATIO,
    localparam int unsigned VWIDTH = virt_width(ATE_PINS, FAST_PINS, RATIO)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ATE_PINS-1:0] ate_in,
    output logic [ATE_PINS-1:0] ate_out,
    output logic [VWIDTH-1:0]   tam_out,
    input  logic [VWIDTH-1:0]   tam_in,
    output logic              slow_en
);
    // R1: elaboration-time bounds on the parameters
    generate
        if (VWIDTH > WMAX) begin : g_bad_width
            $error("virtual width exceeds WMAX");
        end
        if (RATIO < 2) begin : g_bad_ratio
            $error("RATIO must be at least 2");
        end
        if (FAST_PINS < 1 || FAST_PINS >= ATE_PINS) begin : g_bad_split
            $error("FAST_PINS must leave at least one fast and one slow pin");
        end
    endgenerate

    logic last_phase;

    vtam_phase #(.RATIO(RATIO)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .last_phase (last_phase),
        .strobe     (slow_en)
    );

    // Fast lanes: one collector and one packer per fast pin
    genvar g;
    generate
        for (g = 0; g < FAST_PINS; g++) begin : g_fast
            vtam_sipo #(.RATIO(RATIO)) u_sipo (
                .clk        (clk),
                .rst        (rst),
                .last_phase (last_phase),
                .bit_in     (ate_in[g]),
                .word       (tam_out[g*RATIO +: RATIO])
            );
            vtam_piso #(.RATIO(RATIO)) u_piso (
                .clk        (clk),
                .rst        (rst),
                .last_phase (last_phase),
                .par_in     (tam_in[g*RATIO +: RATIO]),
                .bit_out    (ate_out[g])
            );
        end
    endgenerate

    // Slow pass-through lanes, both directions, aligned to the same edge
    typedef struct packed {
        logic [SLOW_PINS-1:0] to_core;
        logic [SLOW_PINS-1:0] to_ate;
    } pass_st_t;

    pass_st_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (last_phase) begin
            ps_d.to_core = ate_in[ATE_PINS-1:FAST_PINS];
            ps_d.to_ate  = tam_in[VWIDTH-1:FAST_LINES];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ps_q <= '0;
        else     ps_q <= ps_d;
    end

    assign tam_out[VWIDTH-1:FAST_LINES]  = ps_q.to_core;
    assign ate_out[ATE_PINS-1:FAST_PINS] = ps_q.to_ate;
endmodule

// File: rtl/vtam_rate_bridge_chk.sv
module vtam_rate_bridge_chk #(
    parameter int unsigned ATE_PINS  = 4,
    parameter int unsigned FAST_PINS = 2,
    parameter int unsigned RATIO     = 4,
    parameter int unsigned VWIDTH    = 10
) (
    input logic                clk,
    input logic                rst,
    input logic [ATE_PINS-1:0] ate_out,
    input logic [VWIDTH-1:0]   tam_out,
    input logic                slow_en
);
    localparam int unsigned GW = $clog2(RATIO + 1) + 1;

    // cycles since the last strobe (or since reset), saturating
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)                  gap_q <= '0;
        else if (slow_en)         gap_q <= GW'(1);
        else if (gap_q <= GW'(RATIO)) gap_q <= gap_q + 1'b1;
    end

    a_r2_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
        slow_en |-> (gap_q == GW'(RATIO)));

    a_r2_strobe_due: assert property (@(posedge clk) disable iff (rst)
        (gap_q == GW'(RATIO)) |-> slow_en);

    a_r4_tam_hold: assert property (@(posedge clk) disable iff (rst)
        !slow_en |-> $stable(tam_out));

    a_r7_slow_resp_hold: assert property (@(posedge clk) disable iff (rst)
        !slow_en |-> $stable(ate_out[ATE_PINS-1:FAST_PINS]));

    a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tam_out == '0 && ate_out == '0 && !slow_en));
endmodule

bind vtam_rate_bridge vtam_rate_bridge_chk #(
    .ATE_PINS  (ATE_PINS),
    .FAST_PINS (FAST_PINS),
    .RATIO     (RATIO),
    .VWIDTH    (VWIDTH)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ate_out (ate_out),
    .tam_out (tam_out),
    .slow_en (slow_en)
);

// File: tb/vtam_rate_bridge_tb.sv
module vtam_rate_bridge_tb;
    localparam int unsigned ATE  = 4;
    localparam int unsigned FP   = 2;
    localparam int unsigned N    = 4;
    localparam int unsigned SP   = ATE - FP;
    localparam int unsigned FL   = FP * N;
    localparam int unsigned VW   = SP + FL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [ATE-1:0] ate_in = '0;
    logic [ATE-1:0] ate_out;
    logic [VW-1:0]  tam_out;
    logic [VW-1:0]  tam_in = '0;
    logic          slow_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [VW-1:0] prev_word;
    logic [VW-1:0] prev_resp;
    bit            have_prev;

    always #10 clk = ~clk;

    vtam_rate_bridge #(.ATE_PINS(ATE), .FAST_PINS(FP), .RATIO(N), .WMAX(16)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .ate_in  (ate_in),
        .ate_out (ate_out),
        .tam_out (tam_out),
        .tam_in  (tam_in),
        .slow_en (slow_en)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Reset; ends on the negedge where rst drops, which begins phase 0
    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 tam_out cleared", 32'(tam_out), 32'h0);
        check("R8 ate_out cleared", 32'(ate_out), 32'h0);
        check("R2 slow_en low in reset", 32'(slow_en), 32'h0);
        rst = 1'b0;
        prev_word = '0;
        prev_resp = '0;
        have_prev = 0;
    endtask

    // One slow period: drives word/resp, checks previous period's results
    task automatic slow_period(input logic [VW-1:0] word, input logic [VW-1:0] resp);
        for (int p = 0; p < int'(N); p++) begin
            check("R4 tam_out holds previous word", 32'(tam_out), 32'(prev_word));
            check("R2 slow_en phase", 32'(slow_en), 32'(p == 0 && have_prev));
            for (int g = 0; g < int'(FP); g++)
                check("R6 fast response bit order", 32'(ate_out[g]), 32'(prev_resp[g*N + p]));
            check("R7 slow response pins", 32'(ate_out[ATE-1:FP]), 32'(prev_resp[VW-1:FL]));
            for (int g = 0; g < int'(FP); g++)
                ate_in[g] = word[g*N + p];
            // R5/R6: outside the last phase drive the complement, which must be ignored
            if (p == int'(N) - 1) begin
                ate_in[ATE-1:FP] = word[VW-1:FL];
                tam_in = resp;
            end else begin
                ate_in[ATE-1:FP] = ~word[VW-1:FL];
                tam_in = ~resp;
            end
            @(negedge clk);
        end
        prev_word = word;
        prev_resp = resp;
        have_prev = 1;
    endtask

    task automatic test_reset_and_width();
        do_reset();
        check("R1 virtual width", 32'($bits(tam_out)), 32'd10);
    endtask

    task automatic test_patterns();
        // R3 R5 R6 R7: walking, alternating and dense patterns
        slow_period(10'b01_0000_0001, 10'b10_1000_0001);
        slow_period(10'b10_1010_0101, 10'b01_0101_1010);
        slow_period(10'b11_1111_1111, 10'b00_0000_0000);
        slow_period(10'b00_1000_0100, 10'b11_0001_0010);
        slow_period(10'b01_0110_1001, 10'b10_1110_0111);
        slow_period(10'b00_0000_0000, 10'b00_0000_0000);
    endtask

    task automatic test_midperiod_reset();
        // R8: reset after loading the packers, in a non-zero phase
        slow_period(10'b11_1100_0011, 10'b11_1111_1111);
        ate_in = '1;
        @(negedge clk);
        @(negedge clk);
        do_reset();
        slow_period(10'b10_0011_1100, 10'b01_1001_0110);
        slow_period(10'b00_0000_0000, 10'b00_0000_0000);
        slow_period(10'b00_0000_0000, 10'b00_0000_0000);
    endtask

    initial begin
        @(negedge clk);
        test_reset_and_width();
        test_patterns();
        test_midperiod_reset();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule